// File: doc/BRIEF.md
# Snapshot Shadow Register File for a Timekeeping Core

This block is the host-facing register file of a real-time clock. It sits between a simple single-cycle read/write port and a free-running timekeeping counter core. It keeps a shadow copy of every time-of-day byte, so the host never reads a byte that is changing. It also lets the host stage a complete new time and hand it to the core as one atomic load. The core itself never stops counting.

Address 0 holds a control and status byte with three bits: a freeze bit, a write-enable bit and an oscillator-failure flag. When freeze is set, the shadow stops following the core, so a multi-byte read sees one consistent instant. When write-enable is set, the host may overwrite the shadow bytes. Clearing write-enable starts a commit. After a fixed number of cycles the staged bytes are handed to the core on a one-cycle load strobe, and the same bytes are kept as the base time for later recovery. At all other times every shadow byte is refreshed from the core together, in the same cycle.

Top module: `rtcShadowRegs`

## Requirements
- R1: After reset the control byte reads 0x00, `busy` and `loadStrobe` are 0, and `baseTime` is all zeros.
- R2: The control byte at address 0 holds freeze in bit 0, write-enable in bit 1 and the oscillator-failure flag in bit 2. Its other bits read 0. Time bytes sit at addresses 1 to TIME_REGS, where address k+1 holds byte k of `liveTime`. Higher addresses read 0, and writes to them have no effect.
- R3: While freeze is 0, write-enable is 0 and `busy` is 0, every time byte reads the value `liveTime` had in the previous cycle. All bytes come from the same sample.
- R4: Writing 1 to freeze holds every shadow byte while the core keeps counting. Starting in the second cycle after freeze is cleared, all bytes again track the core.
- R5: A host write to a time byte while write-enable is 0 is ignored.
- R6: While write-enable is 1, host writes land in the addressed shadow byte and read back unchanged. The shadow is not refreshed from the core.
- R7: A write that takes write-enable from 1 to 0 raises `busy` for exactly COMMIT_DELAY cycles. `loadStrobe` is high for one cycle, the last cycle of that window, and `loadValue` then carries the staged bytes.
- R8: `baseTime` changes only on a commit, and then takes the committed bytes.
- R9: `oscFailEvt` sets the oscillator-failure flag. A control-byte write clears the flag, by writing 0 to bit 2, only while write-enable is already 1. Writing 1 to that bit never sets it.
- R10: After a commit the shadow resumes tracking the core, which now counts on from the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host write strobe |
| hostAddr | input | ADDR_W | Host register address |
| hostWrData | input | DATA_W | Host write data |
| hostRdData | output | DATA_W | Read data for `hostAddr` (combinational) |
| liveTime | input | TIME_REGS*DATA_W | Running time bytes from the counter core |
| oscFailEvt | input | 1 | Oscillator-failure detection pulse |
| loadStrobe | output | 1 | One-cycle load of `loadValue` into the core |
| loadValue | output | TIME_REGS*DATA_W | Shadow bytes offered to the core |
| baseTime | output | TIME_REGS*DATA_W | Last committed time |
| busy | output | 1 | Commit pending |

## Verification
The hardest case to reach is clearing the oscillator-failure flag. The flag can be cleared only with write-enable already high, so the clear always leads to a second commit of whatever the shadow holds at that moment. The stimulus reads all shadow bytes back through the port just before that commit and queues them as the expected load. A scoreboard monitor compares every load strobe against this queue. A second case is reaching a frozen shadow while the core runs on. The stimulus freezes the shadow, attempts an ignored write, and then confirms that the bytes track the counter again after the release.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;
  localparam int FREEZE_BIT = 0;
  localparam int WEN_BIT    = 1;
  localparam int OSCF_BIT   = 2;

  typedef struct packed {
    logic refresh;   // copy core bytes into shadow
    logic shadowWr;  // host write to one shadow byte
    logic flagsWr;   // host write to control byte
    logic commit;    // hand staged bytes to core
  } shadowStrobes_t;
endpackage

// File: rtl/rtcShadowCtrl.sv
module rtcShadowCtrl
  import rtc_shadow_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int TIME_REGS    = 8,
  parameter int COMMIT_DELAY = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              wrWBit,
  input  logic              freezeQ,
  input  logic              wEnQ,
  output shadowStrobes_t    strobes,
  output logic              busy
);
  localparam int CNT_W = (COMMIT_DELAY < 2) ? 1 : $clog2(COMMIT_DELAY);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(COMMIT_DELAY - 1);
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(TIME_REGS);

  logic             busyQ;
  logic [CNT_W-1:0] cntQ;
  logic             flagsHit;
  logic             wFall;

  assign flagsHit = hostWrEn && (hostAddr == '0);
  assign wFall    = flagsHit && wEnQ && !wrWBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
    end else if (wFall) begin
      busyQ <= 1'b1;
      cntQ  <= '0;
    end else if (busyQ) begin
      if (cntQ == LAST_CNT) begin
        busyQ <= 1'b0;
      end else begin
        cntQ <= cntQ + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.flagsWr  = flagsHit;
    strobes.shadowWr = hostWrEn && wEnQ && (hostAddr != '0) && (hostAddr <= TOP_ADDR);
    strobes.commit   = busyQ && (cntQ == LAST_CNT);
    strobes.refresh  = !freezeQ && !wEnQ && !busyQ;
  end

  assign busy = busyQ;
endmodule

// File: rtl/rtcShadowData.sv
module rtcShadowData
  import rtc_shadow_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int TIME_REGS = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  shadowStrobes_t                strobes,
  input  logic [ADDR_W-1:0]             hostAddr,
  input  logic [DATA_W-1:0]             hostWrData,
  input  logic [TIME_REGS*DATA_W-1:0]   liveTime,
  input  logic                          oscFailEvt,
  output logic [DATA_W-1:0]             hostRdData,
  output logic [TIME_REGS*DATA_W-1:0]   loadValue,
  output logic [TIME_REGS*DATA_W-1:0]   baseTime,
  output logic                          freezeQ,
  output logic                          wEnQ,
  output logic                          oscFailQ
);
  logic [TIME_REGS-1:0][DATA_W-1:0] shadow;
  logic [TIME_REGS-1:0][DATA_W-1:0] liveBytes;
  logic unusedWrBits;

  assign liveBytes    = liveTime;
  assign unusedWrBits = ^hostWrData[DATA_W-1:OSCF_BIT+1];

  for (genvar i = 0; i < TIME_REGS; i++) begin : g_byte
    logic hit;
    assign hit = strobes.shadowWr && (hostAddr == ADDR_W'(i + 1));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shadow[i] <= '0;
      end else if (strobes.refresh) begin
        shadow[i] <= liveBytes[i];
      end else if (hit) begin
        shadow[i] <= hostWrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freezeQ  <= 1'b0;
      wEnQ     <= 1'b0;
      oscFailQ <= 1'b0;
    end else begin
      if (strobes.flagsWr) begin
        freezeQ <= hostWrData[FREEZE_BIT];
        wEnQ    <= hostWrData[WEN_BIT];
      end
      if (oscFailEvt) begin
        oscFailQ <= 1'b1;
      end else if (strobes.flagsWr && wEnQ && !hostWrData[OSCF_BIT]) begin
        oscFailQ <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseTime <= '0;
    end else if (strobes.commit) begin
      baseTime <= shadow;
    end
  end

  assign loadValue = shadow;

  always_comb begin
    hostRdData = '0;
    if (hostAddr == '0) begin
      hostRdData[FREEZE_BIT] = freezeQ;
      hostRdData[WEN_BIT]    = wEnQ;
      hostRdData[OSCF_BIT]   = oscFailQ;
    end
    for (int i = 0; i < TIME_REGS; i++) begin
      if (hostAddr == ADDR_W'(i + 1)) hostRdData = shadow[i];
    end
  end
endmodule

// File: rtl/rtcShadowRegs.sv
module rtcShadowRegs
  import rtc_shadow_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 8,
  parameter int TIME_REGS    = 8,
  parameter int COMMIT_DELAY = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        hostWrEn,
  input  logic [ADDR_W-1:0]           hostAddr,
  input  logic [DATA_W-1:0]           hostWrData,
  output logic [DATA_W-1:0]           hostRdData,
  input  logic [TIME_REGS*DATA_W-1:0] liveTime,
  input  logic                        oscFailEvt,
  output logic                        loadStrobe,
  output logic [TIME_REGS*DATA_W-1:0] loadValue,
  output logic [TIME_REGS*DATA_W-1:0] baseTime,
  output logic                        busy
);
  shadowStrobes_t strobes;
  logic freezeQ;
  logic wEnQ;
  logic oscFailQ;

  rtcShadowCtrl #(
    .ADDR_W(ADDR_W), .TIME_REGS(TIME_REGS), .COMMIT_DELAY(COMMIT_DELAY)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .wrWBit(hostWrData[WEN_BIT]), .freezeQ(freezeQ), .wEnQ(wEnQ),
    .strobes(strobes), .busy(busy)
  );

  rtcShadowData #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIME_REGS(TIME_REGS)
  ) data_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .liveTime(liveTime), .oscFailEvt(oscFailEvt),
    .hostRdData(hostRdData), .loadValue(loadValue), .baseTime(baseTime),
    .freezeQ(freezeQ), .wEnQ(wEnQ), .oscFailQ(oscFailQ)
  );

  assign loadStrobe = strobes.commit;
endmodule

// File: rtl/rtcShadowRegs_chk.sv
module rtcShadowRegs_chk #(
  parameter int DATA_W       = 8,
  parameter int TIME_REGS    = 8,
  parameter int COMMIT_DELAY = 4
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        busy,
  input logic                        loadStrobe,
  input logic [TIME_REGS*DATA_W-1:0] loadValue,
  input logic [TIME_REGS*DATA_W-1:0] baseTime,
  input logic                        freezeBit,
  input logic                        wEnBit,
  input logic                        oscFailBit
);
  logic [31:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1;
    else busyCnt <= '0;
  end

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyCnt == 32'(COMMIT_DELAY)));

  // R7
  load_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |-> busy);

  // R7
  load_ends_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |=> !busy);

  // R8
  base_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadStrobe |=> $stable(baseTime));

  // R4
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (freezeBit && !wEnBit && !busy) |=> $stable(loadValue));

  // R9
  oscf_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(oscFailBit) |-> $past(wEnBit));
endmodule

bind rtcShadowRegs rtcShadowRegs_chk #(
  .DATA_W(DATA_W), .TIME_REGS(TIME_REGS), .COMMIT_DELAY(COMMIT_DELAY)
) chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .loadStrobe(loadStrobe),
  .loadValue(loadValue), .baseTime(baseTime), .freezeBit(freezeQ),
  .wEnBit(wEnQ), .oscFailBit(oscFailQ)
);

// File: tb/rtcShadowRegs_tb_top.sv
module rtcShadowRegs_tb_top;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int TREGS  = 8;
  localparam int DLY    = 4;
  localparam int TW     = TREGS * DATA_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              hostWrEn = 1'b0;
  logic [ADDR_W-1:0] hostAddr = '0;
  logic [DATA_W-1:0] hostWrData = '0;
  logic [DATA_W-1:0] hostRdData;
  logic [TW-1:0]     liveTime;
  logic              oscFailEvt = 1'b0;
  logic              loadStrobe;
  logic [TW-1:0]     loadValue;
  logic [TW-1:0]     baseTime;
  logic              busy;

  int total = 0;
  int bad = 0;
  logic [TW-1:0] expQ[$];

  always #5 clk = ~clk;

  rtcShadowRegs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIME_REGS(TREGS), .COMMIT_DELAY(DLY)) dut_i (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .liveTime(liveTime),
    .oscFailEvt(oscFailEvt), .loadStrobe(loadStrobe), .loadValue(loadValue),
    .baseTime(baseTime), .busy(busy)
  );

  function automatic logic [TW-1:0] initTime();
    logic [TW-1:0] v;
    for (int i = 0; i < TREGS; i++) v[i*DATA_W +: DATA_W] = DATA_W'(8'h10 + i);
    return v;
  endfunction

  // core model: byte 0 ticks every cycle, loads on strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) liveTime <= initTime();
    else if (loadStrobe) liveTime <= loadValue;
    else liveTime[DATA_W-1:0] <= liveTime[DATA_W-1:0] + 1'b1;
  end

  task automatic check(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] v);
    hostAddr = a;
    #1 v = hostRdData;
  endtask

  task automatic readCheck(input string req, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp);
    logic [DATA_W-1:0] v;
    readReg(a, v);
    check(req, TW'(v), TW'(exp));
  endtask

  // driver: snapshot staged bytes through the port and queue them
  task automatic pushStaged(output logic [TW-1:0] staged);
    logic [DATA_W-1:0] v;
    for (int i = 0; i < TREGS; i++) begin
      readReg(ADDR_W'(i + 1), v);
      staged[i*DATA_W +: DATA_W] = v;
    end
    expQ.push_back(staged);
  endtask

  // monitor: compare each load against the scoreboard queue
  always @(negedge clk) begin
    if (rstN && loadStrobe) begin
      if (expQ.size() == 0) check("R7 unexpected load", loadValue, '0);
      else check("R7 load value", loadValue, expQ.pop_front());
    end
  end

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] frozen;
    logic [TW-1:0] staged;
    repeat (3) @(negedge clk);
    // R1 reset state
    readCheck("R1 flags", 4'd0, 8'h00);
    check("R1 busy", TW'(busy), '0);
    check("R1 loadStrobe", TW'(loadStrobe), '0);
    check("R1 baseTime", baseTime, '0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R3 tracking with one-cycle lag
    readCheck("R3 byte0", 4'd1, liveTime[7:0] - 8'd1);
    readCheck("R3 byte4", 4'd5, 8'h14);
    @(negedge clk);
    readCheck("R3 byte0 again", 4'd1, liveTime[7:0] - 8'd1);

    // R4 freeze
    hostWrite(4'd0, 8'h01);
    readCheck("R2 freeze bit", 4'd0, 8'h01);
    readReg(4'd1, frozen);
    check("R4 frozen sample", TW'(frozen), TW'(liveTime[7:0] - 8'd1));
    repeat (5) @(negedge clk);
    readCheck("R4 held", 4'd1, frozen);
    // R5 ignored while write-enable is 0
    hostWrite(4'd3, 8'hAA);
    readCheck("R5 write ignored", 4'd3, 8'h12);
    readCheck("R5 held byte0", 4'd1, frozen);
    hostWrite(4'd0, 8'h00);
    @(negedge clk);
    readCheck("R4 resumed byte0", 4'd1, liveTime[7:0] - 8'd1);
    readCheck("R4 resumed byte7", 4'd8, 8'h17);

    // R6 staging
    hostWrite(4'd0, 8'h02);
    readCheck("R2 wen bit", 4'd0, 8'h02);
    for (int i = 1; i <= TREGS; i++) hostWrite(ADDR_W'(i), DATA_W'(8'h50 + i));
    repeat (3) @(negedge clk);
    for (int i = 1; i <= TREGS; i++) readCheck("R6 readback", ADDR_W'(i), DATA_W'(8'h50 + i));
    // R2 unmapped address
    hostWrite(4'd12, 8'h77);
    readCheck("R2 unmapped reads 0", 4'd12, 8'h00);

    // R7 commit timing
    pushStaged(staged);
    hostWrite(4'd0, 8'h00);
    for (int j = 0; j < DLY; j++) begin
      check("R7 busy window", TW'(busy), TW'(1));
      check("R7 strobe position", TW'(loadStrobe), TW'(j == DLY - 1));
      check("R8 base before commit", baseTime, '0);
      @(negedge clk);
    end
    check("R7 busy cleared", TW'(busy), '0);
    check("R8 base after commit", baseTime, staged);
    @(negedge clk);
    // R10 counts on from loaded value
    readCheck("R10 loaded byte3", 4'd4, 8'h54);
    readCheck("R10 loaded byte1", 4'd2, 8'h52);
    @(negedge clk);
    readCheck("R10 tracking byte0", 4'd1, liveTime[7:0] - 8'd1);

    // R9 oscillator-failure flag
    @(negedge clk); oscFailEvt = 1'b1;
    @(negedge clk); oscFailEvt = 1'b0;
    readCheck("R9 flag set", 4'd0, 8'h04);
    hostWrite(4'd0, 8'h00);
    readCheck("R9 clear ignored without wen", 4'd0, 8'h04);
    hostWrite(4'd0, 8'h02);
    readCheck("R9 wen set", 4'd0, 8'h06);
    hostWrite(4'd0, 8'h02);
    readCheck("R9 cleared", 4'd0, 8'h02);
    hostWrite(4'd0, 8'h06);
    readCheck("R9 write one ignored", 4'd0, 8'h02);
    pushStaged(staged);
    hostWrite(4'd0, 8'h00);
    repeat (DLY + 2) @(negedge clk);
    check("R8 second base", baseTime, staged);
    check("R7 queue drained", TW'(expQ.size()), '0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule